// File: doc/BRIEF.md
# Systolic Match-Length Array

This block is the string-matching core of a sliding-window dictionary compressor. A short search string of `LS` symbols (the lookahead) is loaded into a row of processing elements, one symbol per element, where it stays. The window symbols then stream into the first element, one per accepted cycle. Each element forwards the symbol to its neighbour through a one-stage register. In every cycle, each element compares its stored symbol with the window symbol it currently holds and raises an equality flag.

Element `j` sees window symbol `X[i+j]` two accepts later than element `j-1` sees `X[i+j-1]`. A delay line per element therefore realigns the flags, so that all `LS` flags belonging to one start position `i` arrive at the encoder together. The encoder reports `li`, the number of leading lookahead symbols that match the window from position `i`. It counts until the first mismatch, not the total number of matches. Each result carries the start position, taken modulo the window length `WIN`, so that a later stage can pick the best match.

The whole pipeline advances only on accepted symbols. Idle cycles on the input therefore change nothing but timing. A load of a new lookahead string flushes all symbols in flight and starts a new search.

Top module: `lzsa_match_array`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), `li`, `li_valid`, `li_pos` and `match_flags` are all zero.
- R2: A clock edge with `y_load` high copies lookahead symbol `j` from `y_data[j*W +: W]`. It discards every window symbol in flight and forces `li_valid` low at that edge. `x_valid` in the same cycle is ignored. Without `y_load`, `y_data` has no effect.
- R3: For start position `i`, `li` equals the smallest `j` for which lookahead symbol `j` differs from window symbol `X[i+j]`. A mismatch at element 0 gives 0, whatever the other elements report.
- R4: When all `LS` lookahead symbols match from position `i`, `li` equals `LS`.
- R5: Window symbols are numbered from 0 since the last reset or load, counting only edges with `x_valid` high and `y_load` low. The result for position `i` appears with `li_valid` high right after the clock edge that follows the edge accepting `X[i+2*LS-2]`. No result appears before `2*LS-1` symbols have been accepted.
- R6: Cycles with `x_valid` low do not alter the sequence of `li` results. `li_valid` is high for exactly one cycle per accepted symbol once the pipeline is full.
- R7: `li_pos` gives the start position `i` of the current result modulo `WIN`. It restarts at 0 after reset or a load.
- R8: `li`, `li_pos` and `match_flags` change only in cycles where `li_valid` is high.
- R9: With a result, `match_flags[j]` is 1 exactly when lookahead symbol `j` equals `X[i+j]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| y_load | input | 1 | Load strobe for the lookahead string; also flushes the pipeline |
| y_data | input | LS*W | Lookahead symbols; symbol j in bits j*W +: W |
| x_valid | input | 1 | Window symbol present on x_data |
| x_data | input | W | Window symbol |
| li | output | $clog2(LS+1) | Prefix match length for start position li_pos |
| li_valid | output | 1 | li, li_pos and match_flags hold a new result |
| li_pos | output | $clog2(WIN) | Start position of the result, modulo WIN |
| match_flags | output | LS | Aligned equality flags of the result, bit j for element j |

## Verification
A wrong skew depth in any flag delay line pairs a flag with the wrong start position. Unless the data are uniform, `li` and `match_flags` diverge from the reference at the first result, `2*LS-1` accepts after a load. A mistimed or ungated advance shows up as `li_valid` pulses in the wrong cycles, most clearly in the stalled stream. A stale valid bit after a load produces an early `li_valid` in the cycle right after the strobe. An encoder that counts ones instead of scanning for the first mismatch is exposed by isolated corruptions of the first window symbol of an alignment. A wrap error in the position counter shows at the 512th result of the long stream.

// File: rtl/lzsa_pkg.sv
package lzsa_pkg;

  // Aligned flag: v = the compared window symbol was real, e = equality
  typedef struct packed {
    logic v;
    logic e;
  } flag_t;

  // Number of accepts that flag j must wait so that it meets flag LS-1
  function automatic int skew_depth(input int ls, input int j);
    return 2 * (ls - 1 - j);
  endfunction

  // Accepted window symbols before the first start position is complete
  function automatic int fill_accepts(input int ls);
    return 2 * ls - 1;
  endfunction

endpackage

// File: rtl/lzsa_pe.sv
module lzsa_pe #(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             adv,
  input  logic [W-1:0]     y_in,
  input  logic [W-1:0]     x_in,
  input  logic             v_in,
  output logic [W-1:0]     x_out,
  output logic             v_out,
  output lzsa_pkg::flag_t  flag
);

  logic [W-1:0] y_q;
  logic [W-1:0] x_q;
  logic         v_q;
  logic         sym_eq;

  always_ff @(posedge clk) begin
    if (rst) begin
      y_q <= '0;
      x_q <= '0;
      v_q <= 1'b0;
    end else if (flush) begin
      y_q <= y_in;
      v_q <= 1'b0;
    end else if (adv) begin
      x_q <= x_in;
      v_q <= v_in;
    end
  end

  assign sym_eq = (x_q == y_q);
  assign x_out  = x_q;
  assign v_out  = v_q;
  assign flag.v = v_q;
  assign flag.e = sym_eq & v_q;

  AST_PE_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    flush |=> !v_out) else $error("pe kept a symbol across a load"); // R2

endmodule

// File: rtl/lzsa_deskew.sv
module lzsa_deskew #(
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             adv,
  input  lzsa_pkg::flag_t  din,
  output lzsa_pkg::flag_t  dout
);

  lzsa_pkg::flag_t sr [DEPTH];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      for (int k = 0; k < DEPTH; k++) sr[k] <= '0;
    end else if (adv) begin
      sr[0] <= din;
      for (int k = 1; k < DEPTH; k++) sr[k] <= sr[k-1];
    end
  end

  assign dout = sr[DEPTH-1];

  AST_DESKEW_NO_FALSE_HIT: assert property (@(posedge clk) disable iff (rst)
    dout.e |-> dout.v) else $error("equality flag without a real symbol"); // R9

endmodule

// File: rtl/lzsa_lenc.sv
module lzsa_lenc #(
  parameter int LS  = 16,
  parameter int WIN = 512,
  localparam int LW = $clog2(LS + 1),
  localparam int PW = $clog2(WIN)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            flush,
  input  logic            adv,
  input  logic [LS-1:0]   al_e,
  input  logic            al_v,
  output logic [LW-1:0]   li,
  output logic            li_valid,
  output logic [PW-1:0]   li_pos,
  output logic [LS-1:0]   match_flags
);

  // Index of the first cleared flag, LS when none is cleared
  function automatic logic [LW-1:0] prefix_run(input logic [LS-1:0] f);
    logic [LW-1:0] r;
    logic          stop;
    r    = '0;
    stop = 1'b0;
    for (int j = 0; j < LS; j++) begin
      if (!stop) begin
        if (f[j]) r = r + LW'(1);
        else      stop = 1'b1;
      end
    end
    return r;
  endfunction

  // Ones in the n lowest positions
  function automatic logic [LS-1:0] low_mask(input logic [LW-1:0] n);
    logic [LS-1:0] m;
    for (int j = 0; j < LS; j++) m[j] = (j < int'(n));
    return m;
  endfunction

  function automatic logic [PW-1:0] pos_step(input logic [PW-1:0] p);
    return (p == PW'(WIN - 1)) ? '0 : p + PW'(1);
  endfunction

  logic          fresh_q;
  logic          emit;
  logic [LW-1:0] run_len;
  logic [PW-1:0] pos_cnt;

  assign run_len = prefix_run(al_e);
  assign emit    = fresh_q & al_v & ~flush;

  always_ff @(posedge clk) begin
    if (rst) begin
      fresh_q <= 1'b0;
    end else begin
      fresh_q <= adv;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      li          <= '0;
      li_valid    <= 1'b0;
      li_pos      <= '0;
      match_flags <= '0;
      pos_cnt     <= '0;
    end else begin
      li_valid <= emit;
      if (flush) begin
        pos_cnt <= '0;
      end else if (emit) begin
        li          <= run_len;
        li_pos      <= pos_cnt;
        match_flags <= al_e;
        pos_cnt     <= pos_step(pos_cnt);
      end
    end
  end

  AST_LI_PREFIX: assert property (@(posedge clk) disable iff (rst)
    li_valid |-> ((match_flags & low_mask(li)) == low_mask(li))) else $error("li runs past a mismatch"); // R3
  AST_LI_FIRST_ZERO: assert property (@(posedge clk) disable iff (rst)
    (li_valid && (int'(li) < LS)) |-> !match_flags[li]) else $error("li stops on a match"); // R3
  AST_LI_BOUND: assert property (@(posedge clk) disable iff (rst)
    li_valid |-> (int'(li) <= LS)) else $error("li exceeds lookahead length"); // R4
  AST_LI_HELD: assert property (@(posedge clk) disable iff (rst)
    !li_valid |-> ($stable(li) && $stable(li_pos) && $stable(match_flags))) else $error("result moved without valid"); // R8
  AST_EMIT_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    li_valid |-> $past(adv, 2)) else $error("result without an accepted symbol"); // R6
  AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (rst)
    flush |=> !li_valid) else $error("result right after a load"); // R2

endmodule

// File: rtl/lzsa_match_array.sv
module lzsa_match_array #(
  parameter int W   = 8,
  parameter int LS  = 16,
  parameter int WIN = 512,
  localparam int LW = $clog2(LS + 1),
  localparam int PW = $clog2(WIN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              y_load,
  input  logic [LS*W-1:0]   y_data,
  input  logic              x_valid,
  input  logic [W-1:0]      x_data,
  output logic [LW-1:0]     li,
  output logic              li_valid,
  output logic [PW-1:0]     li_pos,
  output logic [LS-1:0]     match_flags
);

  logic              adv;
  logic [W-1:0]      x_chain [LS];
  logic [LS-1:0]     v_chain;
  lzsa_pkg::flag_t   raw_flag [LS];
  lzsa_pkg::flag_t   al_flag  [LS];
  logic [LS-1:0]     al_e;
  logic [LS-1:0]     al_v_all;

  // Load wins over a symbol offered in the same cycle
  assign adv = x_valid & ~y_load;

  for (genvar j = 0; j < LS; j++) begin : g_pe
    logic [W-1:0] x_feed;
    logic         v_feed;
    if (j == 0) begin : g_head
      assign x_feed = x_data;
      assign v_feed = 1'b1;
    end else begin : g_link
      assign x_feed = x_chain[j-1];
      assign v_feed = v_chain[j-1];
    end

    lzsa_pe #(.W(W)) u_pe (
      .clk   (clk),
      .rst   (rst),
      .flush (y_load),
      .adv   (adv),
      .y_in  (y_data[j*W +: W]),
      .x_in  (x_feed),
      .v_in  (v_feed),
      .x_out (x_chain[j]),
      .v_out (v_chain[j]),
      .flag  (raw_flag[j])
    );

    localparam int SKEW = lzsa_pkg::skew_depth(LS, j);
    if (SKEW == 0) begin : g_direct
      assign al_flag[j] = raw_flag[j];
    end else begin : g_delay
      lzsa_deskew #(.DEPTH(SKEW)) u_dsk (
        .clk   (clk),
        .rst   (rst),
        .flush (y_load),
        .adv   (adv),
        .din   (raw_flag[j]),
        .dout  (al_flag[j])
      );
    end

    assign al_e[j]     = al_flag[j].e;
    assign al_v_all[j] = al_flag[j].v;
  end

  lzsa_lenc #(.LS(LS), .WIN(WIN)) u_enc (
    .clk         (clk),
    .rst         (rst),
    .flush       (y_load),
    .adv         (adv),
    .al_e        (al_e),
    .al_v        (al_v_all[0]),
    .li          (li),
    .li_valid    (li_valid),
    .li_pos      (li_pos),
    .match_flags (match_flags)
  );

  // Element 0 carries the newest start position, so its valid comes last
  AST_FILL_ORDER: assert property (@(posedge clk) disable iff (rst)
    al_v_all[0] |-> (&al_v_all)) else $error("start position incomplete at encoder"); // R5
  AST_RESULT_NEEDS_FILL: assert property (@(posedge clk) disable iff (rst)
    li_valid |-> v_chain[LS-1]) else $error("result before array filled"); // R5

endmodule

// File: tb/sim_lzsa_match_array.sv
`timescale 1ns/1ps
module sim_lzsa_match_array;

  localparam int W   = 8;
  localparam int LS  = 16;
  localparam int WIN = 512;
  localparam int LW  = $clog2(LS + 1);
  localparam int PW  = $clog2(WIN);
  localparam int FILL = 2 * LS - 1;

  logic              clk = 1'b0;
  logic              rst;
  logic              y_load;
  logic [LS*W-1:0]   y_data;
  logic              x_valid;
  logic [W-1:0]      x_data;
  logic [LW-1:0]     li;
  logic              li_valid;
  logic [PW-1:0]     li_pos;
  logic [LS-1:0]     match_flags;

  lzsa_match_array #(.W(W), .LS(LS), .WIN(WIN)) u0 (
    .clk(clk), .rst(rst), .y_load(y_load), .y_data(y_data),
    .x_valid(x_valid), .x_data(x_data), .li(li), .li_valid(li_valid),
    .li_pos(li_pos), .match_flags(match_flags)
  );

  always #2 clk = ~clk;

  int n_vec  = 0;
  int n_fail = 0;
  logic [W-1:0] xs [0:1023];
  logic [W-1:0] ys [0:LS-1];
  logic [W-1:0] ys_new [0:LS-1];
  int  nx = 0;
  int  exp_i = 0;
  logic hA = 1'b0, hB = 1'b0;
  int  last_li = 0;
  int  cyc = 0;

  task automatic ck(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (time %0t)", tag, act, exp, $time);
    end
  endtask

  function automatic int ref_len(input int i);
    int r;
    r = 0;
    for (int j = 0; j < LS; j++) begin
      if (ys[j] != xs[i+j]) break;
      r++;
    end
    return r;
  endfunction

  function automatic int ref_flags(input int i);
    int f;
    f = 0;
    for (int j = 0; j < LS; j++)
      if (ys[j] == xs[i+j]) f = f | (1 << j);
    return f;
  endfunction

  function automatic logic [W-1:0] y_sym(input int kind, input int j);
    case (kind)
      0: return 8'h41;
      1: return W'(j + 1);
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [W-1:0] x_sym(input int kind, input int k);
    case (kind)
      0: return 8'h41;
      1: begin
        if (k % 48 == 0)  return 8'hEE;
        if (k % 48 == 21) return 8'hEE;
        if (k % 70 == 33) return 8'h00;
        return W'((k % 16) + 1);
      end
      default: return (((k * 13) % 11) == 0 || (k % 29) == 3) ? 8'h01 : 8'h00;
    endcase
  endfunction

  // One clock: check what the previous edges produced, then drive the next edge
  task automatic do_cycle(input logic ld, input logic xv, input logic [W-1:0] xd, input string ttag);
    logic d;
    @(negedge clk);
    cyc++;
    ck(ttag, int'(li_valid), int'(hA));
    if (li_valid) begin
      ck("R3", int'(li), ref_len(exp_i));
      ck("R7", int'(li_pos), exp_i % WIN);
      ck("R9", int'(match_flags), ref_flags(exp_i));
      last_li = int'(li);
      exp_i++;
    end else begin
      ck("R8", int'(li), last_li);
    end
    y_load  = ld;
    x_valid = xv;
    x_data  = xd;
    if (ld) begin
      for (int j = 0; j < LS; j++) y_data[j*W +: W] = ys_new[j];
      for (int j = 0; j < LS; j++) ys[j] = ys_new[j];
      nx = 0; exp_i = 0; hA = 1'b0; hB = 1'b0;
    end else begin
      y_data = {LS{8'hA5 ^ W'(cyc)}};
      d = 1'b0;
      if (xv) begin
        xs[nx] = xd;
        nx++;
        d = (nx >= FILL);
      end
      hA = hB;
      hB = d;
    end
  endtask

  task automatic t_load(input int kind);
    for (int j = 0; j < LS; j++) ys_new[j] = y_sym(kind, j);
    do_cycle(1'b1, 1'b1, 8'hC3, "R2");
  endtask

  task automatic t_stream(input string ttag, input int kind, input int count, input bit gaps, input int idle);
    int start;
    start = nx;
    while (nx < start + count) begin
      if (gaps && (cyc % 3 == 1 || cyc % 7 == 0))
        do_cycle(1'b0, 1'b0, 8'h5A, ttag);
      else
        do_cycle(1'b0, 1'b1, x_sym(kind, nx), ttag);
    end
    for (int k = 0; k < idle; k++) do_cycle(1'b0, 1'b0, 8'h5A, ttag);
    if (idle > 0) ck(ttag, exp_i, (nx >= FILL) ? nx - FILL + 1 : 0);
  endtask

  task automatic t_reset;
    rst = 1'b1; y_load = 1'b0; x_valid = 1'b0; x_data = '0; y_data = '1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    ck("R1", int'(li_valid), 0);
    ck("R1", int'(li), 0);
    ck("R1", int'(li_pos), 0);
    ck("R1", int'(match_flags), 0);
    last_li = 0;
  endtask

  // R4: every start position matches in full
  task automatic t_full_match;
    t_load(0);
    t_stream("R5", 0, 40, 1'b0, 4);
  endtask

  // R3: corrupted leading symbols give zero despite many matching elements
  task automatic t_first_zero;
    t_load(1);
    t_stream("R5", 1, 130, 1'b0, 4);
  endtask

  // R6: stalls between symbols do not change the results
  task automatic t_stalls;
    t_load(2);
    t_stream("R6", 2, 150, 1'b1, 5);
  endtask

  // R7: long stream past the position wrap
  task automatic t_wrap;
    t_load(2);
    t_stream("R7", 2, 560, 1'b0, 4);
  endtask

  // R2: a load in the middle of a full pipeline restarts the search
  task automatic t_reload;
    t_load(1);
    t_stream("R2", 1, 50, 1'b0, 0);
    t_load(0);
    t_stream("R2", 0, 40, 1'b0, 4);
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_full_match();
    t_first_zero();
    t_stalls();
    t_wrap();
    t_reload();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule